// File: doc/BRIEF.md
# Two-Wire Serial Slave Mailbox

This block is a slave on a two-wire serial bus that lets an external microcontroller trade short messages with a host-side agent. A fast system clock samples the bus clock and data lines. Every bus event is taken from these samples: START, STOP, bit sampling and data-line changes.

A microcontroller write addresses the slave and then sends three bytes: a pointer byte and two payload bytes. The block turns these into a single message, made of the pointer and a 16-bit payload, and pulses it out on the message port. For the other direction, the host side loads a four-byte mailbox word. The block then pulls an active-low interrupt, and the microcontroller fetches the word with a read transaction. The mailbox byte sent first is chosen by the pointer left behind by an earlier write.

The data line is open-drain. The block only ever asks for the line to be pulled low. The bus clock is never stretched.

Top module: `twi_mailbox`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0111000, with bit 0 giving the direction (0x70 write, 0x71 read). Any other address is not acknowledged, and the slave leaves the data line undriven until the next START.
- R2: In a write, the first byte after the address is stored as the pointer and the next two bytes are the payload. When the second payload byte completes, `msg_valid_o` pulses for exactly one cycle. In that cycle `msg_addr_o` holds the pointer, `msg_data_o[7:0]` the first payload byte and `msg_data_o[15:8]` the second.
- R3: In a write, any byte after the second payload byte is not acknowledged and produces no message.
- R4: A read sends mailbox bytes most significant bit first. It starts at index `pointer mod 4` and continues through successive indices, wrapping after index 3. Mailbox byte k is `host_data_i[8k+7:8k]` as it was at the last load.
- R5: After the master answers a transmitted byte with a not-acknowledge, the slave stops driving the data line and keeps it undriven through any further clock pulses until the next START.
- R6: `irq_n_o` goes low on the cycle after `host_load_i`. It stays low until the acknowledge slot of the fourth byte sent in one read transaction, and then returns high. A load in the same cycle as that slot keeps it low.
- R7: A STOP in the middle of a transaction abandons it without producing a message. A repeated START restarts address reception at once.
- R8: After reset, `irq_n_o` is high, `sda_drive_o` is low, `msg_valid_o` is low and the pointer is zero.
- R9: The slave starts pulling the data line low only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Resolved level of the bus data line |
| sda_drive_o | output | 1 | 1 pulls the data line low, 0 releases it |
| host_load_i | input | 1 | Loads the mailbox word from the host side |
| host_data_i | input | 32 | Mailbox word; byte k at bits 8k+7:8k |
| msg_valid_o | output | 1 | One-cycle strobe for a message from the microcontroller |
| msg_addr_o | output | 8 | Pointer byte of the message |
| msg_data_o | output | 16 | Payload of the message, first byte low |
| irq_n_o | output | 1 | Active-low interrupt: mailbox data waits |

## Verification
The bench sweeps read pointers 0 to 3 plus a pointer above 3 against several mailbox words. A design that ignored the pointer, did not wrap, or sent bytes least significant bit first would return bytes in the wrong order or with mirrored bits.

It sends foreign addresses and keeps clocking the bus afterwards. It also keeps clocking after a not-acknowledge on a read. A design that kept driving in either case would pull the line low while it should be free.

Further cases cover a fourth payload byte, a STOP in the middle of a byte and a repeated START. These catch a design that acknowledges too much, emits a message for an abandoned write, or fails to restart.

The interrupt is checked after a pointer-only write and after a partial read, where it must stay low, and after a full four-byte read, where it must rise. A design that cleared it on any access would fail the first two checks.

// File: rtl/twi_mbx_pkg.sv
package twi_mbx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACKW,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_IGNORE
    } bus_st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [BYTE_W-1:0]   addr;
        logic [2*BYTE_W-1:0] data;
    } msg_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] own);
        return b[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_mbx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_s
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain  <= '1;
                prv[g] <= 1'b1;
            end else begin
                chain  <= {chain[STAGES-2:0], raw[g]};
                prv[g] <= chain[STAGES-1];
            end
        end
        assign cur[g] = chain[STAGES-1];
    end

    // index 1 is the clock line, index 0 the data line
    assign scl_s    = cur[1];
    assign ev.rise  = cur[1] & ~prv[1];
    assign ev.fall  = ~cur[1] & prv[1];
    assign ev.start = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign ev.stop  = cur[1] & prv[1] & ~prv[0] & cur[0];
    assign ev.sda   = cur[0];

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
    import twi_mbx_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h38,
    parameter int         MBOX_BYTES = 4,
    localparam int        IDX_W      = $clog2(MBOX_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [IDX_W-1:0]  tx_idx,
    output logic              msg_stb,
    output msg_t              msg,
    output logic              rd_done,
    output logic              sda_drive
);
    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [BIT_W-1:0] ALL_BITS = BIT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MBOX_BYTES - 1);

    bus_st_e           st;
    logic [BIT_W-1:0]  bit_cnt;
    logic [2:0]        byte_idx;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] d_lo;
    logic [IDX_W-1:0]  rd_cnt;
    logic              first_pass;
    logic              is_read;
    logic              ack_nxt;
    logic [BYTE_W-1:0] rx_byte;

    assign rx_byte = {rx_sh[BYTE_W-2:0], ev.sda};
    assign tx_idx  = ptr[IDX_W-1:0] + rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            d_lo       <= '0;
            rd_cnt     <= '0;
            first_pass <= 1'b0;
            is_read    <= 1'b0;
            ack_nxt    <= 1'b0;
            sda_drive  <= 1'b0;
            msg_stb    <= 1'b0;
            msg        <= '0;
            rd_done    <= 1'b0;
        end else begin
            msg_stb <= 1'b0;
            rd_done <= 1'b0;
            if (ev.start) begin
                st         <= ST_RX;
                bit_cnt    <= '0;
                byte_idx   <= '0;
                sda_drive  <= 1'b0;
                rd_cnt     <= '0;
                first_pass <= 1'b1;
            end else if (ev.stop) begin
                st        <= ST_IDLE;
                sda_drive <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise) begin
                            rx_sh <= rx_byte;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                st      <= ST_RX_ACKW;
                                if (byte_idx != 3'd4) byte_idx <= byte_idx + 3'd1;
                                case (byte_idx)
                                    3'd0: begin
                                        ack_nxt <= addr_hit(rx_byte, SLAVE_ADDR);
                                        is_read <= rx_byte[0];
                                    end
                                    3'd1: begin
                                        ack_nxt <= 1'b1;
                                        ptr     <= rx_byte;
                                    end
                                    3'd2: begin
                                        ack_nxt <= 1'b1;
                                        d_lo    <= rx_byte;
                                    end
                                    3'd3: begin
                                        ack_nxt <= 1'b1;
                                        msg_stb <= 1'b1;
                                        msg     <= '{addr: ptr, data: {rx_byte, d_lo}};
                                    end
                                    default: ack_nxt <= 1'b0;
                                endcase
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RX_ACKW: begin
                        if (ev.fall) begin
                            sda_drive <= ack_nxt;
                            st        <= ST_RX_ACK;
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.fall) begin
                            if (!ack_nxt) begin
                                sda_drive <= 1'b0;
                                st        <= ST_IGNORE;
                            end else if (is_read) begin
                                tx_sh     <= tx_byte;
                                sda_drive <= ~tx_byte[BYTE_W-1];
                                bit_cnt   <= '0;
                                st        <= ST_TX;
                            end else begin
                                sda_drive <= 1'b0;
                                st        <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bit_cnt == ALL_BITS) begin
                                sda_drive <= 1'b0;
                                st        <= ST_TX_ACK;
                            end else begin
                                tx_sh     <= tx_sh << 1;
                                sda_drive <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.rise) begin
                            rd_cnt <= rd_cnt + 1'b1;
                            if (first_pass && rd_cnt == LAST_IDX) begin
                                rd_done    <= 1'b1;
                                first_pass <= 1'b0;
                            end
                            st <= ev.sda ? ST_IGNORE : ST_TX_NEXT;
                        end
                    end
                    ST_TX_NEXT: begin
                        if (ev.fall) begin
                            tx_sh     <= tx_byte;
                            sda_drive <= ~tx_byte[BYTE_W-1];
                            bit_cnt   <= '0;
                            st        <= ST_TX;
                        end
                    end
                    default: begin
                        sda_drive <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_mbox_store.sv
module twi_mbox_store
    import twi_mbx_pkg::*;
#(
    parameter int  MBOX_BYTES = 4,
    localparam int IDX_W      = $clog2(MBOX_BYTES),
    localparam int WORD_W     = MBOX_BYTES * BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_load,
    input  logic [WORD_W-1:0]   host_data,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                rd_done,
    input  logic                msg_stb,
    input  msg_t                msg_in,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                irq_n,
    output logic                msg_valid,
    output msg_t                msg_out
);
    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] lanes [MBOX_BYTES];

    for (genvar g = 0; g < MBOX_BYTES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign rd_byte = lanes[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            word      <= '0;
            irq_n     <= 1'b1;
            msg_valid <= 1'b0;
            msg_out   <= '0;
        end else begin
            if (host_load) begin
                word  <= host_data;
                irq_n <= 1'b0;
            end else if (rd_done) begin
                irq_n <= 1'b1;
            end
            msg_valid <= msg_stb;
            if (msg_stb) msg_out <= msg_in;
        end
    end

endmodule

// File: rtl/twi_mailbox.sv
module twi_mailbox
    import twi_mbx_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h38,
    parameter int         MBOX_BYTES  = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_drive_o,
    input  logic                         host_load_i,
    input  logic [MBOX_BYTES*BYTE_W-1:0] host_data_i,
    output logic                         msg_valid_o,
    output logic [BYTE_W-1:0]            msg_addr_o,
    output logic [2*BYTE_W-1:0]          msg_data_o,
    output logic                         irq_n_o
);
    localparam int IDX_W = $clog2(MBOX_BYTES);

    bus_ev_t           ev;
    logic              scl_s;
    logic [IDX_W-1:0]  tx_idx;
    logic [BYTE_W-1:0] tx_byte;
    logic              msg_stb;
    msg_t              msg_int;
    msg_t              msg_q;
    logic              rd_done;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev),
        .scl_s (scl_s)
    );

    twi_byte_engine #(.SLAVE_ADDR(SLAVE_ADDR), .MBOX_BYTES(MBOX_BYTES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .tx_byte   (tx_byte),
        .tx_idx    (tx_idx),
        .msg_stb   (msg_stb),
        .msg       (msg_int),
        .rd_done   (rd_done),
        .sda_drive (sda_drive_o)
    );

    twi_mbox_store #(.MBOX_BYTES(MBOX_BYTES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .host_load (host_load_i),
        .host_data (host_data_i),
        .rd_idx    (tx_idx),
        .rd_done   (rd_done),
        .msg_stb   (msg_stb),
        .msg_in    (msg_int),
        .rd_byte   (tx_byte),
        .irq_n     (irq_n_o),
        .msg_valid (msg_valid_o),
        .msg_out   (msg_q)
    );

    assign msg_addr_o = msg_q.addr;
    assign msg_data_o = msg_q.data;

endmodule

// File: rtl/twi_mailbox_chk.sv
module twi_mailbox_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_drive_o,
    input logic host_load_i,
    input logic irq_n_o,
    input logic msg_valid_o
);
    // R9
    drive_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_o) |-> !$past(scl_s));

    // R6
    load_irq_chk: assert property (@(posedge clk) disable iff (rst)
        host_load_i |=> !irq_n_o);

    // R6
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n_o) |-> !$past(host_load_i));

    // R2
    msg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid_o |=> !msg_valid_o);

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n_o && !sda_drive_o && !msg_valid_o));

endmodule

bind twi_mailbox twi_mailbox_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_s       (scl_s),
    .sda_drive_o (sda_drive_o),
    .host_load_i (host_load_i),
    .irq_n_o     (irq_n_o),
    .msg_valid_o (msg_valid_o)
);

// File: tb/twi_mailbox_bench.sv
module twi_mailbox_bench;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        host_load = 1'b0;
    logic [31:0] host_data = '0;
    logic        sda_drive;
    logic        msg_valid;
    logic [7:0]  msg_addr;
    logic [15:0] msg_data;
    logic        irq_n;
    logic        sda_line;

    int n_chk = 0;
    int n_err = 0;
    int msg_cnt = 0;
    logic [7:0]  last_addr = '0;
    logic [15:0] last_data = '0;
    logic quiet = 1'b0;
    int quiet_viol = 0;
    int edge_viol = 0;
    logic drive_q = 1'b0;

    assign sda_line = m_sda & ~sda_drive;

    always #2 clk = ~clk;

    twi_mailbox u_twi_mailbox (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_drive_o (sda_drive),
        .host_load_i (host_load),
        .host_data_i (host_data),
        .msg_valid_o (msg_valid),
        .msg_addr_o  (msg_addr),
        .msg_data_o  (msg_data),
        .irq_n_o     (irq_n)
    );

    always @(negedge clk) begin
        if (msg_valid) begin
            msg_cnt   <= msg_cnt + 1;
            last_addr <= msg_addr;
            last_data <= msg_data;
        end
        if (quiet && sda_drive) quiet_viol <= quiet_viol + 1;
        if (!rst && sda_drive && !drive_q && m_scl) edge_viol <= edge_viol + 1;
        drive_q <= sda_drive;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic load_host(input logic [31:0] w);
        @(negedge clk);
        host_load = 1'b1;
        host_data = w;
        @(negedge clk);
        host_load = 1'b0;
        @(negedge clk);
        chk("R6 irq low after load", {31'd0, irq_n}, 32'd0);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte(8'h70, a);
        send_byte(p, a);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] rb;
        int base;
        logic [31:0] words [3];
        logic [7:0] ptrs [5];
        words[0] = 32'h44332211;
        words[1] = 32'h80FF017E;
        words[2] = 32'hC3A55A3C;
        ptrs[0] = 8'd0; ptrs[1] = 8'd1; ptrs[2] = 8'd2; ptrs[3] = 8'd3; ptrs[4] = 8'd6;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 irq_n", {31'd0, irq_n}, 32'd1);
        chk("R8 drive", {31'd0, sda_drive}, 32'd0);
        chk("R8 msg_valid", {31'd0, msg_valid}, 32'd0);

        // R2 write messages under several patterns
        for (int t = 0; t < 4; t++) begin
            logic [7:0] p, d0, d1;
            p  = 8'(8'h05 + 37 * t);
            d0 = 8'(8'hA1 ^ (t * 8'h4D));
            d1 = 8'(8'h5B + t * 8'h91);
            base = msg_cnt;
            bus_start();
            send_byte(8'h70, a);
            chk("R1 write address ack", {31'd0, a}, 32'd1);
            send_byte(p, a);
            send_byte(d0, a);
            send_byte(d1, a);
            chk("R2 payload ack", {31'd0, a}, 32'd1);
            bus_stop();
            chk("R2 message count", msg_cnt, base + 1);
            chk("R2 message addr", {24'd0, last_addr}, {24'd0, p});
            chk("R2 message data", {16'd0, last_data}, {16'd0, d1, d0});
        end

        // R1 foreign addresses are ignored, line stays free
        for (int t = 0; t < 3; t++) begin
            logic [7:0] bad;
            bad = (t == 0) ? 8'h52 : (t == 1) ? 8'h72 : 8'hF1;
            base = msg_cnt;
            bus_start();
            send_byte(bad, a);
            chk("R1 foreign address nack", {31'd0, a}, 32'd0);
            quiet = 1'b1;
            send_byte(8'h12, a);
            send_byte(8'h34, a);
            send_byte(8'h56, a);
            quiet = 1'b0;
            bus_stop();
            chk("R1 line undriven after mismatch", quiet_viol, 0);
            chk("R1 no message after mismatch", msg_cnt, base);
        end

        // R3 extra payload byte
        base = msg_cnt;
        bus_start();
        send_byte(8'h70, a);
        send_byte(8'h21, a);
        send_byte(8'h10, a);
        send_byte(8'h20, a);
        send_byte(8'h30, a);
        chk("R3 extra byte nack", {31'd0, a}, 32'd0);
        bus_stop();
        chk("R3 single message", msg_cnt, base + 1);
        chk("R3 data unchanged by extra", {16'd0, last_data}, 32'h2010);

        // R7 STOP in the middle of a byte
        base = msg_cnt;
        bus_start();
        send_byte(8'h70, a);
        send_byte(8'h44, a);
        send_byte(8'h99, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        chk("R7 abandoned write no message", msg_cnt, base);

        // R7 repeated START
        bus_start();
        send_byte(8'h70, a);
        send_byte(8'h09, a);
        bus_start();
        send_byte(8'h70, a);
        chk("R7 address ack after restart", {31'd0, a}, 32'd1);
        send_byte(8'h02, a);
        send_byte(8'hEE, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R7 message after restart", msg_cnt, base + 1);
        chk("R7 restart pointer", {24'd0, last_addr}, 32'h02);

        // R4 / R6 read sweep over words and pointers
        for (int w = 0; w < 3; w++) begin
            for (int pi = 0; pi < 5; pi++) begin
                load_host(words[w]);
                set_ptr(ptrs[pi]);
                chk("R6 irq held after pointer write", {31'd0, irq_n}, 32'd0);
                bus_start();
                send_byte(8'h71, a);
                chk("R1 read address ack", {31'd0, a}, 32'd1);
                for (int k = 0; k < 4; k++) begin
                    int idx;
                    idx = (int'(ptrs[pi]) + k) % 4;
                    recv_byte(k != 3, rb);
                    chk("R4 read byte", {24'd0, rb}, {24'd0, words[w][idx*8 +: 8]});
                end
                quiet = 1'b1;
                wq();
                quiet = 1'b0;
                bus_stop();
                chk("R6 irq high after full read", {31'd0, irq_n}, 32'd1);
            end
        end

        // R5 early not-acknowledge, then keep clocking
        load_host(32'hDEADBEEF);
        set_ptr(8'd0);
        bus_start();
        send_byte(8'h71, a);
        recv_byte(1'b0, rb);
        chk("R4 first byte", {24'd0, rb}, 32'hEF);
        quiet = 1'b1;
        recv_byte(1'b0, rb);
        chk("R5 line free after nack", {24'd0, rb}, 32'hFF);
        quiet = 1'b0;
        bus_stop();
        chk("R5 no drive after nack", quiet_viol, 0);
        chk("R6 irq stays low after partial read", {31'd0, irq_n}, 32'd0);

        // R6 four bytes with wrap-around acknowledge keeps going
        set_ptr(8'd3);
        bus_start();
        send_byte(8'h71, a);
        for (int k = 0; k < 5; k++) begin
            int idx;
            idx = (3 + k) % 4;
            recv_byte(k != 4, rb);
            chk("R4 wrap read", {24'd0, rb}, {24'd0, 8'(32'hDEADBEEF >> (idx * 8))});
        end
        bus_stop();
        chk("R6 irq released", {31'd0, irq_n}, 32'd1);

        // R9 drive only begins with the clock low
        chk("R9 drive start while clock high", edge_viol, 0);

        finish_run();
    end

endmodule